// File: doc/BRIEF.md
# Shaped Dual-Port RAM / FIFO

This block holds 4096 bits of on-chip storage. Configuration sets the element width to 1, 2, 4 or 8 bits, and the number of elements falls as the width grows. Configuration also picks one of two modes. The first is a synchronous dual-port RAM with two independent ports, A and B. The second is a single-clock FIFO with push/pop handshakes, full and empty flags, an occupancy count and one-cycle overflow and underflow pulses. One clock input stands for whichever global clock the surrounding logic selects.

All shapes share one physical array of 8-bit words. A narrow element is a slice of a physical word, chosen by the low address bits. Data written in one shape can therefore be read back in a known way after a reset into another shape. Shape and mode are captured only while reset is held. Reset clears the FIFO bookkeeping and the read registers. It does not clear the array contents.

Top module: `shaped_bram`

## Requirements
- R1: `cfg_shape` code 0, 1, 2, 3 selects element width 1, 2, 4, 8 bits and depth 4096, 2048, 1024, 512 elements. Read data bits above the element width are 0, and write data bits above it are unused.
- R2: In shape s with w = 2^s, element e lives in physical word e >> (3-s), bits starting at (e mod 2^(3-s))·w. For example, bit k of the byte written in shape 3 at address n is element 8n+k in shape 0.
- R3: Reads are registered. `a_rdata` and `b_rdata` show the element addressed at a rising edge just after that edge. A read in the same cycle as a write to the same element returns the old contents.
- R4: The two ports work independently, and a value written through port A can be read through port B.
- R5: When both ports write the same element in one cycle, port A's value is stored. When they write different elements of one physical word, both values are stored.
- R6: Address bits above log2(depth) are ignored.
- R7: `cfg_shape` and `cfg_fifo` take effect only while `rst_n` is low. Changes while running have no effect. Array contents survive reset.
- R8: In FIFO mode (`cfg_fifo`=1), elements pop in push order. `pop_data` shows the popped element just after the edge that accepts the pop and holds it until the next pop.
- R9: `count` gives the occupancy. `full` is 1 exactly when `count` equals the configured depth, and `empty` is 1 exactly when `count` is 0.
- R10: A push while `full` is dropped, `count` is unchanged by it, and `overflow` is 1 for the one cycle after that edge.
- R11: A pop while `empty` is dropped and `underflow` is 1 for the one cycle after that edge.
- R12: Reset leaves the FIFO empty: `count`=0, `empty`=1, `full`=0, with both pulses and all read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronously released |
| cfg_shape | input | 2 | Element width code, sampled during reset |
| cfg_fifo | input | 1 | 1 selects FIFO mode, sampled during reset |
| a_addr | input | 12 | Port A element address |
| a_wdata | input | 8 | Port A write data (low w bits used) |
| a_we | input | 1 | Port A write enable |
| a_rdata | output | 8 | Port A registered read data |
| b_addr | input | 12 | Port B element address |
| b_wdata | input | 8 | Port B write data (low w bits used) |
| b_we | input | 1 | Port B write enable |
| b_rdata | output | 8 | Port B registered read data |
| push | input | 1 | FIFO write request |
| push_data | input | 8 | FIFO write data |
| pop | input | 1 | FIFO read request |
| pop_data | output | 8 | Last popped element |
| full | output | 1 | FIFO holds depth elements |
| empty | output | 1 | FIFO holds nothing |
| count | output | 13 | FIFO occupancy |
| overflow | output | 1 | Push-while-full pulse |
| underflow | output | 1 | Pop-while-empty pulse |

## Verification
Every result appears exactly one rising edge after the inputs that cause it. This covers RAM read data, popped data, the occupancy count with its flags, and the overflow and underflow pulses. The bench changes inputs only on falling edges and samples at the next falling edge, so each sample sees the state after exactly one rising edge. Shape-mapping checks write in one shape, pulse reset with a new shape code, and read in the new shape. This relies on the array keeping its contents across reset.

// File: rtl/sbram_pkg.sv
package sbram_pkg;
  localparam int DEF_DATA_W     = 8;
  localparam int DEF_TOTAL_BITS = 4096;

  typedef enum logic [1:0] {
    SHAPE_X1 = 2'd0,
    SHAPE_X2 = 2'd1,
    SHAPE_X4 = 2'd2,
    SHAPE_X8 = 2'd3
  } shape_e;
endpackage

// File: rtl/sbram_port_map.sv
// Turns an element address and write data into a physical word index,
// a bit offset, and a lane mask/data pair aligned to that offset.
module sbram_port_map #(
  parameter  int DATA_W     = 8,
  parameter  int TOTAL_BITS = 4096,
  localparam int LOG_DW     = $clog2(DATA_W),
  localparam int SW         = $clog2(LOG_DW + 1),
  localparam int AW         = $clog2(TOTAL_BITS),
  localparam int WA         = $clog2(TOTAL_BITS / DATA_W)
) (
  input  logic [SW-1:0]     shape,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [WA-1:0]     word,
  output logic [LOG_DW-1:0] offset,
  output logic [DATA_W-1:0] emask,
  output logic [DATA_W-1:0] lane_mask,
  output logic [DATA_W-1:0] lane_data
);
  int          sub_n;
  logic [AW-1:0] sub;

  always_comb begin
    sub_n     = LOG_DW - int'(shape);
    word      = WA'(addr >> sub_n);
    sub       = addr & AW'((1 << sub_n) - 1);
    offset    = LOG_DW'(int'(sub) << int'(shape));
    emask     = DATA_W'((1 << (1 << int'(shape))) - 1);
    lane_mask = emask << offset;
    lane_data = (wdata & emask) << offset;
  end
endmodule

// File: rtl/sbram_store.sv
// Physical array of DATA_W-bit words with two masked write lanes and
// two registered, read-first read lanes. Lane 0 wins on overlapping bits.
module sbram_store #(
  parameter  int DATA_W     = 8,
  parameter  int TOTAL_BITS = 4096,
  localparam int WORDS      = TOTAL_BITS / DATA_W,
  localparam int WA         = $clog2(WORDS),
  localparam int OW         = $clog2(DATA_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             we,
  input  logic [1:0]             re,
  input  logic [1:0][WA-1:0]     word,
  input  logic [1:0][OW-1:0]     off,
  input  logic [1:0][DATA_W-1:0] emask,
  input  logic [1:0][DATA_W-1:0] lmask,
  input  logic [1:0][DATA_W-1:0] ldata,
  output logic [1:0][DATA_W-1:0] rd
);
  logic [DATA_W-1:0] mem [WORDS];
  logic              same;
  logic [DATA_W-1:0] am, bm, new_a, new_b;

  always_comb begin
    same  = (word[0] == word[1]);
    am    = we[0] ? lmask[0] : '0;
    bm    = we[1] ? (lmask[1] & ~(same ? am : '0)) : '0;
    new_a = (mem[word[0]] & ~am) | (ldata[0] & am);
    if (same) new_a = (new_a & ~bm) | (ldata[1] & bm);
    new_b = same ? new_a : ((mem[word[1]] & ~bm) | (ldata[1] & bm));
  end

  always_ff @(posedge clk) begin
    if (we[0]) mem[word[0]] <= new_a;
    if (we[1]) mem[word[1]] <= new_b;
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd[p] <= '0;
      else if (re[p]) rd[p] <= (mem[word[p]] >> off[p]) & emask[p];
    end

    // R1
    high_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd[p] & ~emask[p]) == '0);
  end

  // R5
  a_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we[0] && we[1] && same) |=>
      ((mem[$past(word[0])] & $past(lmask[0])) == ($past(ldata[0]) & $past(lmask[0]))));
endmodule

// File: rtl/sbram_fifo_ctl.sv
// Single-clock FIFO pointers and occupancy over the shaped element space.
module sbram_fifo_ctl #(
  parameter  int DATA_W     = 8,
  parameter  int TOTAL_BITS = 4096,
  localparam int LOG_DW     = $clog2(DATA_W),
  localparam int SW         = $clog2(LOG_DW + 1),
  localparam int AW         = $clog2(TOTAL_BITS),
  localparam int CW         = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [SW-1:0] shape,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          udf
);
  logic [CW-1:0] depth;
  logic [AW-1:0] pmask;
  logic [AW-1:0] wr_n, rd_n;
  logic [CW-1:0] cnt_n;
  logic          ovf_n, udf_n;

  always_comb begin
    depth   = CW'(TOTAL_BITS >> shape);
    pmask   = AW'(depth - 1'b1);
    full    = (count == depth);
    empty   = (count == '0);
    push_ok = en & push & ~full;
    pop_ok  = en & pop & ~empty;
  end

  always_comb begin
    wr_n  = wr_ptr;
    rd_n  = rd_ptr;
    cnt_n = count;
    if (push_ok) wr_n = (wr_ptr + 1'b1) & pmask;
    if (pop_ok)  rd_n = (rd_ptr + 1'b1) & pmask;
    case ({push_ok, pop_ok})
      2'b10:   cnt_n = count + 1'b1;
      2'b01:   cnt_n = count - 1'b1;
      default: cnt_n = count;
    endcase
    ovf_n = en & push & full;
    udf_n = en & pop & empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      wr_ptr <= wr_n;
      rd_ptr <= rd_n;
      count  <= cnt_n;
      ovf    <= ovf_n;
      udf    <= udf_n;
    end
  end

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= depth);

  // R9
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && push && full && !pop) |=> (ovf && count == $past(count)));

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pop && empty && !push) |=> (udf && empty));
endmodule

// File: rtl/shaped_bram.sv
module shaped_bram #(
  parameter  int DATA_W     = sbram_pkg::DEF_DATA_W,
  parameter  int TOTAL_BITS = sbram_pkg::DEF_TOTAL_BITS,
  localparam int LOG_DW     = $clog2(DATA_W),
  localparam int SW         = $clog2(LOG_DW + 1),
  localparam int AW         = $clog2(TOTAL_BITS),
  localparam int WA         = $clog2(TOTAL_BITS / DATA_W),
  localparam int CW         = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     cfg_shape,
  input  logic              cfg_fifo,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_we,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [AW-1:0]     b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_we,
  output logic [DATA_W-1:0] b_rdata,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     count,
  output logic              overflow,
  output logic              underflow
);
  logic [SW-1:0] shape_q;
  logic          fifo_q;
  logic          run_q;

  // Configuration is loaded only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shape_q <= cfg_shape;
      fifo_q  <= cfg_fifo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  sbram_fifo_ctl #(.DATA_W(DATA_W), .TOTAL_BITS(TOTAL_BITS)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (fifo_q),
    .shape  (shape_q),
    .push   (push),
    .pop    (pop),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .push_ok(push_ok),
    .pop_ok (pop_ok),
    .count  (count),
    .full   (full),
    .empty  (empty),
    .ovf    (overflow),
    .udf    (underflow)
  );

  // Lane 0 = port A / FIFO write side, lane 1 = port B / FIFO read side.
  logic [1:0][AW-1:0]     l_addr;
  logic [1:0][DATA_W-1:0] l_wdata;
  logic [1:0]             l_we, l_re;
  logic [1:0][WA-1:0]     l_word;
  logic [1:0][LOG_DW-1:0] l_off;
  logic [1:0][DATA_W-1:0] l_emask, l_lmask, l_ldata, l_rd;

  always_comb begin
    l_addr[0]  = fifo_q ? wr_ptr : a_addr;
    l_wdata[0] = fifo_q ? push_data : a_wdata;
    l_we[0]    = fifo_q ? push_ok : a_we;
    l_re[0]    = ~fifo_q;
    l_addr[1]  = fifo_q ? rd_ptr : b_addr;
    l_wdata[1] = b_wdata;
    l_we[1]    = ~fifo_q & b_we;
    l_re[1]    = fifo_q ? pop_ok : 1'b1;
  end

  for (genvar p = 0; p < 2; p++) begin : g_map
    sbram_port_map #(.DATA_W(DATA_W), .TOTAL_BITS(TOTAL_BITS)) u_map (
      .shape    (shape_q),
      .addr     (l_addr[p]),
      .wdata    (l_wdata[p]),
      .word     (l_word[p]),
      .offset   (l_off[p]),
      .emask    (l_emask[p]),
      .lane_mask(l_lmask[p]),
      .lane_data(l_ldata[p])
    );
  end

  sbram_store #(.DATA_W(DATA_W), .TOTAL_BITS(TOTAL_BITS)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (l_we),
    .re   (l_re),
    .word (l_word),
    .off  (l_off),
    .emask(l_emask),
    .lmask(l_lmask),
    .ldata(l_ldata),
    .rd   (l_rd)
  );

  always_comb begin
    a_rdata  = l_rd[0];
    b_rdata  = fifo_q ? '0 : l_rd[1];
    pop_data = fifo_q ? l_rd[1] : '0;
  end

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> ($stable(shape_q) && $stable(fifo_q)));

  // R12
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (count == '0 && empty && !overflow && !underflow));
endmodule

// File: tb/tb_shaped_bram.sv
module tb_shaped_bram;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_shape;
  logic        cfg_fifo;
  logic [11:0] a_addr, b_addr;
  logic [7:0]  a_wdata, b_wdata, a_rdata, b_rdata;
  logic        a_we, b_we;
  logic        push, pop;
  logic [7:0]  push_data, pop_data;
  logic        full, empty, overflow, underflow;
  logic [12:0] count;

  always #4 clk = ~clk;

  shaped_bram dut (
    .clk(clk), .rst_n(rst_n), .cfg_shape(cfg_shape), .cfg_fifo(cfg_fifo),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_rdata(b_rdata),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
    .full(full), .empty(empty), .count(count),
    .overflow(overflow), .underflow(underflow)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] shp, input logic fm);
    rst_n = 1'b0; cfg_shape = shp; cfg_fifo = fm;
    a_we = 0; b_we = 0; push = 0; pop = 0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  typedef struct packed {
    logic        awe; logic [11:0] aad; logic [7:0] awd;
    logic        bwe; logic [11:0] bad; logic [7:0] bwd;
    logic        ca;  logic [7:0]  ea;
    logic        cb;  logic [7:0]  eb;
  } vec_t;

  // Shape x8. R3 read-first, R4 cross-port, R5 collision, R6 high address bits.
  localparam vec_t VT [7] = '{
    '{1'b1, 12'd5,     8'h3C, 1'b1, 12'd9,     8'hA5, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 12'd9,     8'h00, 1'b0, 12'd5,     8'h00, 1'b1, 8'hA5, 1'b1, 8'h3C},
    '{1'b1, 12'd5,     8'h11, 1'b0, 12'd5,     8'h00, 1'b1, 8'h3C, 1'b1, 8'h3C},
    '{1'b0, 12'd5,     8'h00, 1'b1, 12'd5,     8'h22, 1'b1, 8'h11, 1'b1, 8'h11},
    '{1'b1, 12'd7,     8'h77, 1'b1, 12'd7,     8'h88, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 12'd7,     8'h00, 1'b0, 12'd5,     8'h00, 1'b1, 8'h77, 1'b1, 8'h22},
    '{1'b0, 12'h207,   8'h00, 1'b0, 12'hE05,   8'h00, 1'b1, 8'h77, 1'b1, 8'h22}
  };

  initial begin
    rst_n = 1'b0; cfg_shape = 2'd3; cfg_fifo = 1'b0;
    a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    a_we = 0; b_we = 0; push = 0; pop = 0; push_data = '0;
    step();
    do_reset(2'd3, 1'b0);
    // R12 reset state
    chk("R12 a_rdata after reset", 16'(a_rdata), 16'h0);
    chk("R12 count after reset", 16'(count), 16'h0);

    foreach (VT[i]) begin
      a_we = VT[i].awe; a_addr = VT[i].aad; a_wdata = VT[i].awd;
      b_we = VT[i].bwe; b_addr = VT[i].bad; b_wdata = VT[i].bwd;
      step();
      if (VT[i].ca) chk($sformatf("R3/R4/R5/R6 vector %0d port A", i), 16'(a_rdata), 16'(VT[i].ea));
      if (VT[i].cb) chk($sformatf("R3/R4/R5/R6 vector %0d port B", i), 16'(b_rdata), 16'(VT[i].eb));
    end
    a_we = 0; b_we = 0;

    // R2 byte 7 = 0x77 viewed as single bits; R1 upper bits read 0
    do_reset(2'd0, 1'b0);
    a_addr = 12'd56; b_addr = 12'd59; step();
    chk("R2 x1 addr 56", 16'(a_rdata), 16'h01);
    chk("R2 x1 addr 59", 16'(b_rdata), 16'h00);
    a_addr = 12'd60; b_addr = 12'd63; step();
    chk("R1 x1 addr 60", 16'(a_rdata), 16'h01);
    chk("R2 x1 addr 63", 16'(b_rdata), 16'h00);

    // R1 x2: only low 2 data bits written into slice 2 of byte 5 (0x22 -> 0x12)
    do_reset(2'd1, 1'b0);
    a_addr = 12'd22; a_wdata = 8'hFD; a_we = 1; b_addr = 12'd21; step();
    a_we = 0;
    chk("R2 x2 addr 21", 16'(b_rdata), 16'h00);
    step();
    chk("R1 x2 addr 22", 16'(a_rdata), 16'h01);

    // R5 two slices of one word written together in x4 (byte 9 -> 0x16)
    do_reset(2'd2, 1'b0);
    a_addr = 12'd18; a_wdata = 8'hF6; a_we = 1;
    b_addr = 12'd19; b_wdata = 8'h31; b_we = 1; step();
    a_we = 0; b_we = 0; step();
    chk("R5 x4 low nibble", 16'(a_rdata), 16'h06);
    chk("R5 x4 high nibble", 16'(b_rdata), 16'h01);

    // R7 contents kept across reset, new shape honoured
    do_reset(2'd3, 1'b0);
    a_addr = 12'd5; b_addr = 12'd9; step();
    chk("R7 x8 byte 5", 16'(a_rdata), 16'h12);
    chk("R5 x8 byte 9", 16'(b_rdata), 16'h16);
    // R7 change of shape while running is ignored
    cfg_shape = 2'd0; cfg_fifo = 1'b1; step();
    a_addr = 12'd9; step();
    chk("R7 cfg ignored", 16'(a_rdata), 16'h16);

    // FIFO, x8 depth 512
    do_reset(2'd3, 1'b1);
    chk("R12 empty after reset", 16'(empty), 16'h1);
    chk("R12 full after reset", 16'(full), 16'h0);
    push = 1; push_data = 8'h10; step();
    push_data = 8'h20; step();
    push_data = 8'h30; step();
    push = 0;
    chk("R9 count 3", 16'(count), 16'd3);
    pop = 1; step();
    chk("R8 pop 1", 16'(pop_data), 16'h10);
    step();
    chk("R8 pop 2", 16'(pop_data), 16'h20);
    step();
    chk("R8 pop 3", 16'(pop_data), 16'h30);
    pop = 0;
    chk("R9 empty after pops", 16'(empty), 16'h1);
    pop = 1; step();
    pop = 0;
    chk("R11 underflow pulse", 16'(underflow), 16'h1);
    chk("R11 count stays 0", 16'(count), 16'h0);
    chk("R8 pop_data held", 16'(pop_data), 16'h30);
    step();
    chk("R11 underflow clears", 16'(underflow), 16'h0);

    for (int i = 0; i < 512; i++) begin
      push = 1; push_data = 8'(i); step();
    end
    chk("R9 count at depth", 16'(count), 16'd512);
    chk("R9 full at depth", 16'(full), 16'h1);
    push_data = 8'hEE; step();
    push = 0;
    chk("R10 overflow pulse", 16'(overflow), 16'h1);
    chk("R10 count unchanged", 16'(count), 16'd512);
    step();
    chk("R10 overflow clears", 16'(overflow), 16'h0);
    pop = 1; step();
    pop = 0;
    chk("R8 first after wrap", 16'(pop_data), 16'h00);
    chk("R9 count after pop", 16'(count), 16'd511);

    do_reset(2'd3, 1'b1);
    chk("R12 count cleared", 16'(count), 16'h0);
    chk("R12 empty set", 16'(empty), 16'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule